// File: doc/BRIEF.md
# Debug Stop Gate for a Network Interface Port Pair

This block sits on the two port pairs of one interconnect network interface. On the initiator side it passes commands and write data from an initiator into the network, and read data from the network back to the initiator. On the target side it passes commands and write data that the network delivers on to a target, and read data from the target back into the network. Every channel uses a valid/accept handshake, and the block routes each handshake through combinational gating with no added storage.

A debug stop input freezes traffic in one of two granularities, chosen by a mode register. In transaction mode only new initiator commands are refused, and everything already inside the network still drains. In message mode the commands that the network delivers to the target are held back as well. The command and its data then stay in the network's queues because the target handshake never completes. The block counts open read transactions and unfinished write bursts. It raises a registered `blocked` flag once the stopped port has nothing left in flight, so a debugger can poll that flag before it gates the clocks.

Top module: `nif_stop_gate`

## Requirements
- R1: After synchronous reset the open-read and open-write counts are zero, `blocked` is 0, the stop state is clear and the mode is transaction mode (value 0).
- R2: While not stopped, each command handshake passes straight through: the outgoing valid follows the incoming valid, the returned accept follows the downstream accept, and the `read` flag and info payload are copied. This holds as long as the matching counter has room.
- R3: One cycle after `dbg_stop` is sampled high, `m_cmd_accept` and `n_cmd_valid` are held at 0 in both modes, even if the initiator keeps `m_cmd_valid` high.
- R4: In transaction mode (mode value 0) a stop leaves the target command channel and all read data channels passing through.
- R5: In message mode (mode value 1) a stop also holds `t_cmd_valid` and `d_cmd_accept` at 0.
- R6: A write data channel passes beats only while at least one write command on that side has been accepted and has not yet seen its last beat. A burst that has started therefore completes even while stopped, and stray data is refused.
- R7: The initiator read count rises on each accepted read command and falls on each accepted read beat with `last` set. A read command is refused while MAX_OUT reads are open, and a write command is refused while MAX_OUT writes are open. Neither limit blocks the other command type.
- R8: `blocked` is 1 in the cycle after the stop state is set, both initiator counts are zero, and (in message mode) the target write count is zero. Otherwise it is 0.
- R9: One cycle after `dbg_stop` is sampled low the gating opens, and a command that the initiator has held valid throughout is then accepted.
- R10: The mode register loads `cfg_msg_mode` only in a cycle with `cfg_we` high. At other times the mode input has no effect.
- R11: Read data channels are never gated. Valid, accept, data and `last` pass through unchanged in every mode and stop state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_stop | input | 1 | Debug stop request |
| cfg_we | input | 1 | Mode register write enable |
| cfg_msg_mode | input | 1 | Mode to load: 0 transaction, 1 message |
| blocked | output | 1 | Stopped and nothing in flight |
| m_cmd_valid | input | 1 | Initiator command valid |
| m_cmd_accept | output | 1 | Initiator command accept |
| m_cmd_read | input | 1 | Initiator command is a read |
| m_cmd_info | input | IW | Initiator command payload |
| n_cmd_valid | output | 1 | Command valid into network |
| n_cmd_accept | input | 1 | Network command accept |
| n_cmd_read | output | 1 | Read flag into network |
| n_cmd_info | output | IW | Payload into network |
| m_wd_valid | input | 1 | Initiator write data valid |
| m_wd_accept | output | 1 | Initiator write data accept |
| m_wd_data | input | DW | Initiator write data |
| m_wd_last | input | 1 | Last write beat |
| n_wd_valid | output | 1 | Write data valid into network |
| n_wd_accept | input | 1 | Network write data accept |
| n_wd_data | output | DW | Write data into network |
| n_wd_last | output | 1 | Last beat into network |
| n_rd_valid | input | 1 | Read data valid from network |
| n_rd_accept | output | 1 | Read data accept to network |
| n_rd_data | input | DW | Read data from network |
| n_rd_last | input | 1 | Last read beat from network |
| m_rd_valid | output | 1 | Read data valid to initiator |
| m_rd_accept | input | 1 | Initiator read data accept |
| m_rd_data | output | DW | Read data to initiator |
| m_rd_last | output | 1 | Last read beat to initiator |
| d_cmd_valid | input | 1 | Delivered command valid from network |
| d_cmd_accept | output | 1 | Delivered command accept to network |
| d_cmd_read | input | 1 | Delivered command is a read |
| d_cmd_info | input | IW | Delivered command payload |
| t_cmd_valid | output | 1 | Command valid to target |
| t_cmd_accept | input | 1 | Target command accept |
| t_cmd_read | output | 1 | Read flag to target |
| t_cmd_info | output | IW | Payload to target |
| d_wd_valid | input | 1 | Delivered write data valid |
| d_wd_accept | output | 1 | Delivered write data accept |
| d_wd_data | input | DW | Delivered write data |
| d_wd_last | input | 1 | Delivered last beat |
| t_wd_valid | output | 1 | Write data valid to target |
| t_wd_accept | input | 1 | Target write data accept |
| t_wd_data | output | DW | Write data to target |
| t_wd_last | output | 1 | Last beat to target |
| t_rd_valid | input | 1 | Read data valid from target |
| t_rd_accept | output | 1 | Read data accept to target |
| t_rd_data | input | DW | Read data from target |
| t_rd_last | input | 1 | Last read beat from target |
| d_rd_valid | output | 1 | Read data valid into network |
| d_rd_accept | input | 1 | Network read data accept |
| d_rd_data | output | DW | Read data into network |
| d_rd_last | output | 1 | Last read beat into network |

## Verification
The hardest situation to reach is a stop that lands in the middle of a write burst while reads are still open. Here `blocked` must wait for the last data beat and the last read beat, and must rise exactly one cycle after the final one. The stimulus first opens reads and a partial burst with the gate open, then raises the stop. It then retires the remaining beats one at a time and samples `blocked` both just before and just after the expected edge. The message-mode variant repeats this with a target-side burst that was delivered before the mode was switched.

// File: rtl/nif_stop_pkg.sv
package nif_stop_pkg;
  typedef enum logic {
    MODE_TXN = 1'b0,
    MODE_MSG = 1'b1
  } stop_mode_e;
endpackage

// File: rtl/nif_txn_count.sv
// Up/down count of open transactions with full and empty flags.
module nif_txn_count #(
  parameter int MAX_OUT = 4,
  localparam int CW = $clog2(MAX_OUT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam logic [CW-1:0] FULL_V = CW'(MAX_OUT);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (inc && !dec) begin
      count <= count + 1'b1;
    end else if (dec && !inc) begin
      count <= count - 1'b1;
    end
  end

  assign full  = (count == FULL_V);
  assign empty = (count == '0);
endmodule

// File: rtl/nif_stop_ctrl.sv
// Registered stop state, mode register and blocked flag.
module nif_stop_ctrl
  import nif_stop_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       dbg_stop,
  input  logic       cfg_we,
  input  logic       cfg_msg_mode,
  input  logic       ini_quiet,
  input  logic       tgt_quiet,
  output logic       stop_q,
  output stop_mode_e mode_q,
  output logic       blocked
);
  logic quiet;

  assign quiet = ini_quiet && ((mode_q == MODE_TXN) || tgt_quiet);

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q  <= 1'b0;
      mode_q  <= MODE_TXN;
      blocked <= 1'b0;
    end else begin
      stop_q  <= dbg_stop;
      blocked <= stop_q && quiet;
      if (cfg_we) begin
        mode_q <= stop_mode_e'(cfg_msg_mode);
      end
    end
  end
endmodule

// File: rtl/nif_stop_gate.sv
module nif_stop_gate
  import nif_stop_pkg::*;
#(
  parameter int DW      = 8,
  parameter int IW      = 8,
  parameter int MAX_OUT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dbg_stop,
  input  logic          cfg_we,
  input  logic          cfg_msg_mode,
  output logic          blocked,
  input  logic          m_cmd_valid,
  output logic          m_cmd_accept,
  input  logic          m_cmd_read,
  input  logic [IW-1:0] m_cmd_info,
  output logic          n_cmd_valid,
  input  logic          n_cmd_accept,
  output logic          n_cmd_read,
  output logic [IW-1:0] n_cmd_info,
  input  logic          m_wd_valid,
  output logic          m_wd_accept,
  input  logic [DW-1:0] m_wd_data,
  input  logic          m_wd_last,
  output logic          n_wd_valid,
  input  logic          n_wd_accept,
  output logic [DW-1:0] n_wd_data,
  output logic          n_wd_last,
  input  logic          n_rd_valid,
  output logic          n_rd_accept,
  input  logic [DW-1:0] n_rd_data,
  input  logic          n_rd_last,
  output logic          m_rd_valid,
  input  logic          m_rd_accept,
  output logic [DW-1:0] m_rd_data,
  output logic          m_rd_last,
  input  logic          d_cmd_valid,
  output logic          d_cmd_accept,
  input  logic          d_cmd_read,
  input  logic [IW-1:0] d_cmd_info,
  output logic          t_cmd_valid,
  input  logic          t_cmd_accept,
  output logic          t_cmd_read,
  output logic [IW-1:0] t_cmd_info,
  input  logic          d_wd_valid,
  output logic          d_wd_accept,
  input  logic [DW-1:0] d_wd_data,
  input  logic          d_wd_last,
  output logic          t_wd_valid,
  input  logic          t_wd_accept,
  output logic [DW-1:0] t_wd_data,
  output logic          t_wd_last,
  input  logic          t_rd_valid,
  output logic          t_rd_accept,
  input  logic [DW-1:0] t_rd_data,
  input  logic          t_rd_last,
  output logic          d_rd_valid,
  input  logic          d_rd_accept,
  output logic [DW-1:0] d_rd_data,
  output logic          d_rd_last
);
  localparam int CW = $clog2(MAX_OUT + 1);

  logic          stop_q;
  stop_mode_e    mode_q;
  logic          hold_tgt;
  logic [CW-1:0] rd_cnt, wr_cnt, twr_cnt;
  logic          rd_full, rd_empty, wr_full, wr_empty, twr_full, twr_empty;
  logic          ini_room, tgt_room;
  logic          ini_cmd_fire, ini_wd_fire, ini_rd_fire;
  logic          tgt_cmd_fire, tgt_wd_fire;

  // Initiator side: command gated by stop and counter room.
  assign ini_room     = m_cmd_read ? !rd_full : !wr_full;
  assign n_cmd_valid  = m_cmd_valid && !stop_q && ini_room;
  assign m_cmd_accept = n_cmd_accept && !stop_q && ini_room;
  assign n_cmd_read   = m_cmd_read;
  assign n_cmd_info   = m_cmd_info;
  assign ini_cmd_fire = m_cmd_valid && m_cmd_accept;

  // Write data passes only behind an accepted command.
  assign n_wd_valid  = m_wd_valid && !wr_empty;
  assign m_wd_accept = n_wd_accept && !wr_empty;
  assign n_wd_data   = m_wd_data;
  assign n_wd_last   = m_wd_last;
  assign ini_wd_fire = m_wd_valid && m_wd_accept;

  // Read responses are never gated.
  assign m_rd_valid  = n_rd_valid;
  assign n_rd_accept = m_rd_accept;
  assign m_rd_data   = n_rd_data;
  assign m_rd_last   = n_rd_last;
  assign ini_rd_fire = m_rd_valid && m_rd_accept;

  // Target side: delivery withheld only in message mode.
  assign hold_tgt     = stop_q && (mode_q == MODE_MSG);
  assign tgt_room     = d_cmd_read || !twr_full;
  assign t_cmd_valid  = d_cmd_valid && !hold_tgt && tgt_room;
  assign d_cmd_accept = t_cmd_accept && !hold_tgt && tgt_room;
  assign t_cmd_read   = d_cmd_read;
  assign t_cmd_info   = d_cmd_info;
  assign tgt_cmd_fire = d_cmd_valid && d_cmd_accept;

  assign t_wd_valid  = d_wd_valid && !twr_empty;
  assign d_wd_accept = t_wd_accept && !twr_empty;
  assign t_wd_data   = d_wd_data;
  assign t_wd_last   = d_wd_last;
  assign tgt_wd_fire = d_wd_valid && d_wd_accept;

  assign d_rd_valid  = t_rd_valid;
  assign t_rd_accept = d_rd_accept;
  assign d_rd_data   = t_rd_data;
  assign d_rd_last   = t_rd_last;

  nif_txn_count #(.MAX_OUT(MAX_OUT)) i_rd_cnt (
    .clk(clk), .rst(rst),
    .inc(ini_cmd_fire && m_cmd_read),
    .dec(ini_rd_fire && m_rd_last),
    .count(rd_cnt), .full(rd_full), .empty(rd_empty)
  );

  nif_txn_count #(.MAX_OUT(MAX_OUT)) i_wr_cnt (
    .clk(clk), .rst(rst),
    .inc(ini_cmd_fire && !m_cmd_read),
    .dec(ini_wd_fire && m_wd_last),
    .count(wr_cnt), .full(wr_full), .empty(wr_empty)
  );

  nif_txn_count #(.MAX_OUT(MAX_OUT)) i_twr_cnt (
    .clk(clk), .rst(rst),
    .inc(tgt_cmd_fire && !d_cmd_read),
    .dec(tgt_wd_fire && d_wd_last),
    .count(twr_cnt), .full(twr_full), .empty(twr_empty)
  );

  nif_stop_ctrl i_ctrl (
    .clk(clk), .rst(rst),
    .dbg_stop(dbg_stop), .cfg_we(cfg_we), .cfg_msg_mode(cfg_msg_mode),
    .ini_quiet(rd_empty && wr_empty), .tgt_quiet(twr_empty),
    .stop_q(stop_q), .mode_q(mode_q), .blocked(blocked)
  );
endmodule

// File: rtl/nif_stop_gate_chk.sv
module nif_stop_gate_chk #(
  parameter int MAX_OUT = 4
) (
  input logic clk,
  input logic rst,
  input logic dbg_stop,
  input logic stop_q,
  input logic blocked,
  input logic hold_tgt,
  input logic m_cmd_valid,
  input logic m_cmd_accept,
  input logic m_cmd_read,
  input logic n_cmd_valid,
  input logic m_wd_accept,
  input logic t_cmd_valid,
  input logic d_cmd_accept,
  input logic rd_full,
  input logic wr_empty,
  input logic wr_full
);
  // R3: a sampled stop closes the initiator command channel next cycle
  p_ini_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    dbg_stop |=> (!m_cmd_accept && !n_cmd_valid));

  // R5: message-mode hold keeps the target command channel shut
  p_tgt_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    hold_tgt |-> (!t_cmd_valid && !d_cmd_accept));

  // R6: no write data accepted without an open write command
  p_wd_follow_r6: assert property (@(posedge clk) disable iff (rst)
    wr_empty |-> !m_wd_accept);

  // R7: no read accepted while the read count is at its limit
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    rd_full |-> !(m_cmd_valid && m_cmd_accept && m_cmd_read));

  // R7: same for writes
  p_no_wr_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    wr_full |-> !(m_cmd_valid && m_cmd_accept && !m_cmd_read));

  // R8: blocked only follows a cycle in which the stop state was set
  p_blocked_stop_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(blocked) |-> $past(stop_q));
endmodule

bind nif_stop_gate nif_stop_gate_chk #(.MAX_OUT(MAX_OUT)) i_chk (
  .clk(clk), .rst(rst), .dbg_stop(dbg_stop), .stop_q(stop_q),
  .blocked(blocked), .hold_tgt(hold_tgt),
  .m_cmd_valid(m_cmd_valid), .m_cmd_accept(m_cmd_accept),
  .m_cmd_read(m_cmd_read), .n_cmd_valid(n_cmd_valid),
  .m_wd_accept(m_wd_accept), .t_cmd_valid(t_cmd_valid),
  .d_cmd_accept(d_cmd_accept), .rd_full(rd_full),
  .wr_empty(wr_empty), .wr_full(wr_full)
);

// File: tb/test_nif_stop_gate.sv
module test_nif_stop_gate;
  localparam int DW = 8, IW = 8, MAX_OUT = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic dbg_stop = 0, cfg_we = 0, cfg_msg_mode = 0, blocked;
  logic m_cmd_valid = 0, m_cmd_accept, m_cmd_read = 0;
  logic [IW-1:0] m_cmd_info = '0, n_cmd_info, d_cmd_info = '0, t_cmd_info;
  logic n_cmd_valid, n_cmd_accept = 0, n_cmd_read;
  logic m_wd_valid = 0, m_wd_accept, m_wd_last = 0;
  logic [DW-1:0] m_wd_data = '0, n_wd_data, n_rd_data = '0, m_rd_data;
  logic n_wd_valid, n_wd_accept = 0, n_wd_last;
  logic n_rd_valid = 0, n_rd_accept, n_rd_last = 0;
  logic m_rd_valid, m_rd_accept = 0, m_rd_last;
  logic d_cmd_valid = 0, d_cmd_accept, d_cmd_read = 0;
  logic t_cmd_valid, t_cmd_accept = 0, t_cmd_read;
  logic d_wd_valid = 0, d_wd_accept, d_wd_last = 0;
  logic [DW-1:0] d_wd_data = '0, t_wd_data, t_rd_data = '0, d_rd_data;
  logic t_wd_valid, t_wd_accept = 0, t_wd_last;
  logic t_rd_valid = 0, t_rd_accept, t_rd_last = 0;
  logic d_rd_valid, d_rd_accept = 0, d_rd_last;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nif_stop_gate #(.DW(DW), .IW(IW), .MAX_OUT(MAX_OUT)) i_nif_stop_gate (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_state(logic stp, logic msg);
    dbg_stop = stp; cfg_we = 1; cfg_msg_mode = msg;
    tick();
    cfg_we = 0;
  endtask

  task automatic ini_cmd(logic rd, logic exp_acc, string req);
    m_cmd_valid = 1; m_cmd_read = rd; n_cmd_accept = 1;
    #1 chk(req, m_cmd_accept, exp_acc);
    tick();
    m_cmd_valid = 0; n_cmd_accept = 0;
  endtask

  task automatic rd_beat(logic lst);
    n_rd_valid = 1; n_rd_last = lst; m_rd_accept = 1; n_rd_data = 8'h5A;
    #1 chk("R11 rdata", {m_rd_valid, m_rd_last, m_rd_data, n_rd_accept},
           {1'b1, lst, 8'h5A, 1'b1});
    tick();
    n_rd_valid = 0; n_rd_last = 0; m_rd_accept = 0;
  endtask

  task automatic wd_beat(logic lst, logic exp_acc, string req);
    m_wd_valid = 1; m_wd_last = lst; n_wd_accept = 1;
    #1 chk(req, m_wd_accept, exp_acc);
    tick();
    m_wd_valid = 0; m_wd_last = 0; n_wd_accept = 0;
  endtask

  // {stop, msg, mcv, nca, dcv, tca, exp ncv, exp mca, exp tcv, exp dca}
  localparam logic [9:0] VEC [8] = '{
    10'b00_1111_1111,  // R2 open, all handshakes pass
    10'b00_1010_1010,  // R2 valids only
    10'b00_0101_0101,  // R2 accepts only
    10'b10_1111_0011,  // R3 R4 transaction stop
    10'b10_1010_0010,  // R3 R4
    10'b11_1111_0000,  // R3 R5 message stop
    10'b11_0101_0000,  // R5
    10'b01_1111_1111   // R2 message mode, not stopped
  };

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    @(negedge clk); tick(); tick();
    rst = 0;
    chk("R1 blocked", blocked, 0);
    m_cmd_valid = 1; m_cmd_read = 1; n_cmd_accept = 1;
    #1 chk("R1 gate open", {n_cmd_valid, m_cmd_accept}, 2'b11);
    m_cmd_valid = 0; n_cmd_accept = 0;
    dbg_stop = 1; tick(); tick();
    d_cmd_valid = 1; t_cmd_accept = 1;
    #1 chk("R1 mode txn", t_cmd_valid, 1);
    d_cmd_valid = 0; t_cmd_accept = 0;
    chk("R1 R8 idle counts", blocked, 1);
    dbg_stop = 0; tick();

    // Table of combinational gating vectors
    foreach (VEC[i]) begin
      set_state(VEC[i][9], VEC[i][8]);
      m_cmd_valid = VEC[i][7]; n_cmd_accept = VEC[i][6];
      d_cmd_valid = VEC[i][5]; t_cmd_accept = VEC[i][4];
      m_cmd_read = 1; d_cmd_read = 1; m_cmd_info = 8'(i + 3);
      #1 chk("R2 R3 R4 R5 vector", {n_cmd_valid, m_cmd_accept, t_cmd_valid, d_cmd_accept},
             {28'd0, VEC[i][3:0]});
      chk("R2 info", {n_cmd_read, n_cmd_info}, {1'b1, 8'(i + 3)});
      #1 m_cmd_valid = 0; n_cmd_accept = 0; d_cmd_valid = 0; t_cmd_accept = 0;
    end
    set_state(0, 0);
    tick();

    // R7 read limit
    for (int k = 0; k < MAX_OUT; k++) ini_cmd(1, 1, "R7 read accepted");
    ini_cmd(1, 0, "R7 read refused at limit");
    m_cmd_valid = 1; m_cmd_read = 0; n_cmd_accept = 1;
    #1 chk("R7 write not blocked by read limit", m_cmd_accept, 1);
    m_cmd_valid = 0; n_cmd_accept = 0;
    rd_beat(0);
    ini_cmd(1, 0, "R7 non-last beat keeps count");
    rd_beat(1);
    ini_cmd(1, 1, "R7 last beat frees a slot");
    for (int k = 0; k < MAX_OUT - 2; k++) rd_beat(1);

    // R8 blocked waits for reads; R3 holds while valid stays
    dbg_stop = 1; tick(); tick();
    chk("R8 reads open", blocked, 0);
    ini_cmd(1, 0, "R3 stopped refuses");
    rd_beat(1);
    chk("R8 one read left", blocked, 0);
    rd_beat(1);
    chk("R8 before edge", blocked, 0);
    tick();
    chk("R8 after last read", blocked, 1);

    // R9 release with command held
    m_cmd_valid = 1; m_cmd_read = 1; n_cmd_accept = 1;
    tick();
    #1 chk("R3 held valid refused", m_cmd_accept, 0);
    dbg_stop = 0;
    #1 chk("R9 still gated this cycle", m_cmd_accept, 0);
    tick();
    #1 chk("R9 released next cycle", {n_cmd_valid, m_cmd_accept}, 2'b11);
    tick();
    m_cmd_valid = 0; n_cmd_accept = 0;
    rd_beat(1);

    // R6 write bursts
    wd_beat(1, 0, "R6 stray data refused");
    ini_cmd(0, 1, "R6 write cmd");
    wd_beat(0, 1, "R6 first beat");
    dbg_stop = 1; tick(); tick();
    chk("R8 burst open", blocked, 0);
    wd_beat(0, 1, "R6 beat while stopped");
    wd_beat(1, 1, "R6 last beat while stopped");
    chk("R8 before edge after burst", blocked, 0);
    tick();
    chk("R8 after burst", blocked, 1);
    wd_beat(1, 0, "R6 data after burst refused");

    // R5 R10 target side
    set_state(1, 1);
    d_cmd_valid = 1; d_cmd_read = 0; t_cmd_accept = 1;
    #1 chk("R5 target held", {t_cmd_valid, d_cmd_accept}, 2'b00);
    cfg_msg_mode = 0; tick();
    #1 chk("R10 mode ignored without we", t_cmd_valid, 0);
    cfg_we = 1; tick(); cfg_we = 0;
    #1 chk("R4 txn mode delivers", {t_cmd_valid, d_cmd_accept}, 2'b11);
    tick();
    d_cmd_valid = 0; t_cmd_accept = 0;
    set_state(1, 1); tick();
    chk("R8 target burst open", blocked, 0);
    t_rd_valid = 1; d_rd_accept = 1; t_rd_last = 1; t_rd_data = 8'hC3;
    #1 chk("R11 target rdata", {d_rd_valid, t_rd_accept, d_rd_last, d_rd_data},
           {3'b111, 8'hC3});
    t_rd_valid = 0; d_rd_accept = 0; t_rd_last = 0;
    d_wd_valid = 1; d_wd_last = 1; t_wd_accept = 1;
    #1 chk("R6 target burst finishes", {t_wd_valid, d_wd_accept}, 2'b11);
    tick();
    d_wd_valid = 0; d_wd_last = 0; t_wd_accept = 0;
    tick();
    chk("R8 message mode idle", blocked, 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule